// File: doc/BRIEF.md
# Disc Controller Command Busy Timer

This block models how long a disc controller's command processor stays busy. The host writes a command byte. The block decides how many clock cycles that command takes, holds a busy flag for that time, and then raises a completion interrupt together with a response code. The interrupt stays up until the host acknowledges it.

A pause command is slow, and it is slower still in double-speed mode. An initialise command is shorter. It aborts whatever is in progress and clears the mode register. It does not throw away the time that a pending pause still needs. That leftover pause time is added in front of the initialise time, so software that overlaps other long transfers with a pause and then an initialise sees the long combined wait. Any other command arriving while the processor is busy is refused with an error response.

All delays are parameters. The defaults are about one million cycles for a single-speed pause, two million for a double-speed pause, and 80 thousand for an initialise.

Top module: `dct_cmd_timer`

## Requirements
- R1: After reset, `busy`, `irq`, `resp_code` and `mode_q` are all zero.
- R2: A command accepted while idle sets `busy` at the next clock edge. Exactly N edges after the accepting edge, `busy` falls and `irq` rises with `resp_code` = 0x02, where N is the command's delay.
- R3: Pause (code 0x09) takes PAUSE_SGL cycles when `speed_dbl` is 0 at acceptance. It takes the double-speed delay (2*PAUSE_SGL by default) when `speed_dbl` is 1.
- R4: Initialise (code 0x0A) takes INIT_CYC cycles when accepted while idle. It takes the same time when it interrupts a pending command that is not a pause, and the aborted command signals no completion.
- R5: Initialise accepted while a pause is pending completes INIT_CYC edges after the edge on which the pause would have completed. Only one completion is signalled.
- R6: An accepted initialise clears `mode_q` to 0x00 at the next edge. It takes precedence over a simultaneous `mode_wr`.
- R7: A command other than 0x0A written while `busy` is refused. At the next edge `irq` rises with `resp_code` = 0x05, and the pending command's timing is unchanged. In the cycle of a completion, the completion response wins.
- R8: `irq` stays high until `ack` is sampled high. It falls at the next edge unless a new completion or refusal occurs in that same cycle.
- R9: `mode_wr` loads `mode_wdata` into `mode_q` at the next edge, whether or not the processor is busy.
- R10: Any command code other than 0x09 and 0x0A takes GEN_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command byte |
| speed_dbl | input | 1 | 1 = double-speed drive mode |
| ack | input | 1 | Host interrupt acknowledge |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| busy | output | 1 | Command processor busy |
| irq | output | 1 | Interrupt request, held until acknowledged |
| resp_code | output | 8 | Response of the last interrupt (0x02 done, 0x05 refused) |
| mode_q | output | 8 | Mode register |

## Verification
A table of commands issued from idle covers the generic, single-speed pause, double-speed pause and initialise delays. Each one is timed edge by edge, which separates the speed selection and the per-code delay choice from an off-by-one in the countdown. Directed sequences then check the following:
- An initialise issued in the middle of a pause, to show the leftover pause time is kept rather than dropped or restarted.
- An initialise that cuts short a generic command, to show the earlier time is discarded.
- A refused command during a pause, to show the pause deadline does not move.
- Held and acknowledged interrupts.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam logic [7:0] CMD_PAUSE = 8'h09;
   localparam logic [7:0] CMD_INIT  = 8'h0A;
   localparam logic [7:0] RESP_DONE = 8'h02;
   localparam logic [7:0] RESP_ERR  = 8'h05;
endpackage

// File: rtl/dct_delay_sel.sv
module dct_delay_sel
   import dct_pkg::*;
#(
   parameter int CNT_W        = 24,
   parameter int PAUSE_SGL    = 1000000,
   parameter bit DBL_FROM_SGL = 1'b1,
   parameter int PAUSE_DBL    = 2000000,
   parameter int INIT_CYC     = 80000,
   parameter int GEN_CYC      = 4000
) (
   input  logic [7:0]       code,
   input  logic             dbl,
   output logic [CNT_W-1:0] dly
);
   logic [CNT_W-1:0] pause_dbl_v;

   // The double-speed pause delay is either derived from the single-speed one or set on its own.
   generate
      if (DBL_FROM_SGL) begin : g_dbl_derived
         assign pause_dbl_v = CNT_W'(2 * PAUSE_SGL);
      end else begin : g_dbl_own
         assign pause_dbl_v = CNT_W'(PAUSE_DBL);
      end
   endgenerate

   always_comb begin
      unique case (code)
         CMD_PAUSE: dly = dbl ? pause_dbl_v : CNT_W'(PAUSE_SGL);
         CMD_INIT:  dly = CNT_W'(INIT_CYC);
         default:   dly = CNT_W'(GEN_CYC);
      endcase
   end
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   // A load always wins over the countdown finishing in the same cycle.
   assign done = busy && (cnt == CNT_W'(1)) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (load) begin
         busy <= 1'b1;
         cnt  <= load_val;
      end else if (busy) begin
         if (cnt == CNT_W'(1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/dct_irq_ctrl.sv
module dct_irq_ctrl
   import dct_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic       reject,
   input  logic       ack,
   output logic       irq,
   output logic [7:0] resp
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         resp <= '0;
      end else if (done) begin
         irq  <= 1'b1;
         resp <= RESP_DONE;
      end else if (reject) begin
         irq  <= 1'b1;
         resp <= RESP_ERR;
      end else if (ack) begin
         irq  <= 1'b0;
      end
   end
endmodule

// File: rtl/dct_cmd_timer.sv
module dct_cmd_timer
   import dct_pkg::*;
#(
   parameter int PAUSE_SGL    = 1000000,
   parameter bit DBL_FROM_SGL = 1'b1,
   parameter int PAUSE_DBL    = 2000000,
   parameter int INIT_CYC     = 80000,
   parameter int GEN_CYC      = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   input  logic       speed_dbl,
   input  logic       ack,
   input  logic       mode_wr,
   input  logic [7:0] mode_wdata,
   output logic       busy,
   output logic       irq,
   output logic [7:0] resp_code,
   output logic [7:0] mode_q
);
   localparam int PAUSE_MAX = DBL_FROM_SGL ? 2 * PAUSE_SGL : PAUSE_DBL;
   localparam int LONGEST   = (PAUSE_MAX > GEN_CYC) ? PAUSE_MAX : GEN_CYC;
   localparam int CNT_W     = $clog2(LONGEST + INIT_CYC + 1) + 1;

   generate
      if (PAUSE_SGL < 1 || INIT_CYC < 1 || GEN_CYC < 1) begin : g_bad_delay
         $error("dct_cmd_timer: every delay must be at least one cycle");
      end
      if (!DBL_FROM_SGL && PAUSE_DBL < 1) begin : g_bad_dbl
         $error("dct_cmd_timer: PAUSE_DBL must be at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] dly;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic [7:0]       pend_q;
   logic             is_init;
   logic             load;
   logic             reject;
   logic             done;

   dct_delay_sel #(
      .CNT_W(CNT_W), .PAUSE_SGL(PAUSE_SGL), .DBL_FROM_SGL(DBL_FROM_SGL),
      .PAUSE_DBL(PAUSE_DBL), .INIT_CYC(INIT_CYC), .GEN_CYC(GEN_CYC)
   ) u_sel (
      .code(cmd_code), .dbl(speed_dbl), .dly(dly)
   );

   assign is_init = cmd_valid && (cmd_code == CMD_INIT);
   assign load    = (cmd_valid && !busy) || (is_init && busy);
   assign reject  = cmd_valid && busy && !is_init;

   // An initialise that lands on a pending pause inherits the edges the pause still needs.
   always_comb begin
      if (busy && is_init && pend_q == CMD_PAUSE)
         load_val = cnt_q - CNT_W'(1) + CNT_W'(INIT_CYC);
      else
         load_val = dly;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else if (load)
         pend_q <= cmd_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (is_init)
         mode_q <= '0;
      else if (mode_wr)
         mode_q <= mode_wdata;
   end

   dct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .busy(busy), .cnt(cnt_q), .done(done)
   );

   dct_irq_ctrl u_irq (
      .clk(clk), .rst_n(rst_n), .done(done), .reject(reject), .ack(ack),
      .irq(irq), .resp(resp_code)
   );
endmodule

// File: rtl/dct_cmd_timer_chk.sv
module dct_cmd_timer_chk
   import dct_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [7:0]       cmd_code,
   input logic             ack,
   input logic             busy,
   input logic             irq,
   input logic [7:0]       resp_code,
   input logic [7:0]       mode_q,
   input logic [CNT_W-1:0] cnt
);
   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy |=> busy);

   // R2
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt == CNT_W'(1) && !(cmd_valid && cmd_code == CMD_INIT)
      |=> !busy && irq && resp_code == RESP_DONE);

   // R6
   init_mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == CMD_INIT |=> busy && mode_q == 8'h00);

   // R7
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt != CNT_W'(1) && cmd_valid && cmd_code != CMD_INIT
      |=> busy && irq && resp_code == RESP_ERR);

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack |=> irq);
endmodule

bind dct_cmd_timer dct_cmd_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .ack(ack), .busy(busy), .irq(irq), .resp_code(resp_code),
   .mode_q(mode_q), .cnt(cnt_q)
);

// File: tb/tb_dct_cmd_timer.sv
module tb_dct_cmd_timer;
   localparam int PS  = 40;
   localparam int IC  = 25;
   localparam int GC  = 6;
   localparam int WDOG = 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = '0;
   logic       speed_dbl = 1'b0;
   logic       ack = 1'b0;
   logic       mode_wr = 1'b0;
   logic [7:0] mode_wdata = '0;
   logic       busy, irq;
   logic [7:0] resp_code, mode_q;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   dct_cmd_timer #(.PAUSE_SGL(PS), .DBL_FROM_SGL(1'b1), .PAUSE_DBL(1),
                   .INIT_CYC(IC), .GEN_CYC(GC)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .speed_dbl(speed_dbl), .ack(ack), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .busy(busy), .irq(irq), .resp_code(resp_code), .mode_q(mode_q)
   );

   // {code, dbl, expected cycles}
   localparam logic [31:0] VEC [5] = '{
      {8'h01, 8'd0, 16'(GC)},
      {8'h09, 8'd0, 16'(PS)},
      {8'h09, 8'd1, 16'(2*PS)},
      {8'h0A, 8'd0, 16'(IC)},
      {8'hFF, 8'd1, 16'(GC)}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Returns just after the accepting edge.
   task automatic issue(input logic [7:0] c, input logic d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; speed_dbl = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_irq(inout int k);
      while (!irq && k < WDOG) begin
         @(negedge clk);
         k++;
      end
      if (k >= WDOG) chk("watchdog", 0, 1);
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   initial begin
      int k;
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 irq", irq, 0);
      chk("R1 resp", resp_code, 0);
      chk("R1 mode", mode_q, 0);
      rst_n = 1'b1;

      // R2 R3 R10 table walk
      foreach (VEC[i]) begin
         issue(VEC[i][31:24], VEC[i][16]);
         chk("R2 busy after accept", busy, 1);
         k = 0;
         wait_irq(k);
         chk("R2/R3/R10 delay", k, int'(VEC[i][15:0]));
         chk("R2 busy cleared", busy, 0);
         chk("R2 resp done", resp_code, 8'h02);
         do_ack();
      end

      // R8 hold then acknowledge
      issue(8'h01, 1'b0);
      k = 0; wait_irq(k);
      repeat (5) @(negedge clk);
      chk("R8 irq held", irq, 1);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk("R8 irq cleared", irq, 0);

      // R9 mode write, R6 init clears it
      @(negedge clk); mode_wr = 1'b1; mode_wdata = 8'h5A;
      @(negedge clk); mode_wr = 1'b0;
      chk("R9 mode written", mode_q, 8'h5A);
      @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h0A; mode_wr = 1'b1; mode_wdata = 8'h33;
      @(negedge clk); cmd_valid = 1'b0; mode_wr = 1'b0;
      chk("R6 init clears mode", mode_q, 0);
      k = 0; wait_irq(k);
      chk("R4 idle init delay", k, IC);
      do_ack();

      // R5 init in the middle of a pause keeps remaining time
      issue(8'h09, 1'b0);
      @(negedge clk); mode_wr = 1'b1; mode_wdata = 8'hC3;
      @(negedge clk); mode_wr = 1'b0;
      chk("R9 mode write while busy", mode_q, 8'hC3);
      repeat (8) @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h0A;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R6 init mid pause clears mode", mode_q, 0);
      k = 11;
      wait_irq(k);
      chk("R5 pause remainder plus init", k, PS + IC);
      chk("R5 resp done", resp_code, 8'h02);
      do_ack();
      repeat (3) @(negedge clk);
      chk("R5 single completion", irq, 0);

      // R4 init cuts a generic command short
      issue(8'h01, 1'b0);
      cmd_valid = 1'b1; cmd_code = 8'h0A;
      @(negedge clk); cmd_valid = 1'b0;
      k = 0; wait_irq(k);
      chk("R4 init replaces generic", k, IC);
      do_ack();

      // R7 refused command during a pause
      issue(8'h09, 1'b1);
      repeat (5) @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h01;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R7 refuse irq", irq, 1);
      chk("R7 refuse resp", resp_code, 8'h05);
      chk("R7 still busy", busy, 1);
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk("R8 ack clears refusal", irq, 0);
      k = 7;
      wait_irq(k);
      chk("R7 pause timing kept", k, 2 * PS);
      chk("R7 completion resp", resp_code, 8'h02);
      do_ack();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule